// File: doc/BRIEF.md
# Gated-strobe serial DAC register interface

This block is the digital front end of a 12-bit serial-input converter. It runs on a system clock. The serial data line and four strobe lines pass through synchronizers. A data bit is shifted into a 12-bit input register when exactly one strobe makes its active transition while the other three rest at their idle levels. Three of the strobes act on a rising transition. The fourth acts on a falling one, so it idles high.

A pair of active-low load lines, both asserted, copies the input register into the 12-bit DAC register in parallel. Because the register is double-buffered, several converters can be filled one after another and then updated together. An active-low clear zeroes the DAC register at once, without the clock. The clear does not touch the input register.

Top module: `sdac_top`

## Requirements
- R1: Each accepted bit enters bit 0 of the input register, and the older bits move one place toward bit 11. A word therefore arrives most significant bit first and can be read on `shreg_o`.
- R2: `stb_i[0]`, `stb_i[1]` and `stb_i[3]` idle low. A low-to-high transition on one of them takes the current `sdata_i` bit.
- R3: `stb_i[2]` idles high. A high-to-low transition on it takes the current `sdata_i` bit.
- R4: A transition is ignored whenever any other strobe is away from its idle level. This covers two strobes changing in the same sample, and one strobe held active while another pulses.
- R5: A strobe returning to its idle level never takes a bit, so a full pulse on one strobe shifts exactly one bit.
- R6: The DAC register copies the input register only while `load_a_ni` and `load_b_ni` are both low. If either one is high, the DAC register keeps its value.
- R7: A low `clr_ni` forces `dac_o` to 0x000 at once, without waiting for a clock edge. The input register keeps its contents.
- R8: While `clr_ni` is low, load requests have no effect. After `clr_ni` returns high, a load that is still held copies the input register.
- R9: Reset clears both registers and the edge history. Releasing reset with the strobes idle shifts no bit.
- R10: An accepted bit shows on `shreg_o` after the third rising clock edge that follows the strobe transition. A load shows on `dac_o` after the third rising edge that follows both load lines going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data bit |
| stb_i | input | 4 | Strobe lines: [0], [1] and [3] act on a rising edge; [2] acts on a falling edge |
| load_a_ni | input | 1 | First load line, active low |
| load_b_ni | input | 1 | Second load line, active low |
| clr_ni | input | 1 | Asynchronous clear of the DAC register, active low |
| dac_o | output | 12 | DAC register contents |
| shreg_o | output | 12 | Input shift register contents, for debug |

## Verification
The checker tests on every cycle that the DAC register reads zero while clear is low. It also tests that the DAC register holds unless both load lines were low three samples earlier, and that a load copies the input register's previous value. For the input register it tests that a change is always a one-place shift, with the data sampled three cycles before entering bit 0, and that nothing moves while the strobes are steady. Which strobe transitions the gating accepts or rejects cannot be seen from those per-cycle relations. That question, including simultaneous and blocked edges and return edges, is settled by the bench's pulse table and its directed scenarios, along with the exact latency and the behaviour at reset release.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef struct packed {
    logic shift;
    logic data;
  } shift_req_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
  import sdac_pkg::*;
#(
  parameter int unsigned     NSTB     = 4,
  parameter logic [NSTB-1:0] STB_IDLE = 4'b0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSTB-1:0] stb_i,
  input  logic            data_i,
  output shift_req_t      req_o
);
  logic [NSTB-1:0] prev_q, act_now, act_prev, launch;
  logic            single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= STB_IDLE;
    else         prev_q <= stb_i;
  end

  // Strobes are normalised so that 1 means away from the idle level.
  assign act_now  = stb_i  ^ STB_IDLE;
  assign act_prev = prev_q ^ STB_IDLE;
  assign single   = (act_now & (act_now - NSTB'(1))) == '0;

  for (genvar k = 0; k < NSTB; k++) begin : g_stb
    assign launch[k] = act_now[k] & ~act_prev[k] & single;
  end

  assign req_o.shift = |launch;
  assign req_o.data  = data_i;
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  shift_req_t    req_i,
  input  logic          load_i,
  output logic [DW-1:0] shreg_o,
  output logic [DW-1:0] dac_o
);
  logic [DW-1:0] shreg_q, dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shreg_q <= '0;
    else if (req_i.shift) shreg_q <= {shreg_q[DW-2:0], req_i.data};
  end

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) dac_q <= '0;
    else if (load_i)        dac_q <= shreg_q;
  end

  assign shreg_o = shreg_q;
  assign dac_o   = dac_q;
endmodule

// File: rtl/sdac_top.sv
module sdac_top
  import sdac_pkg::*;
#(
  parameter int unsigned     DW          = 12,
  parameter int unsigned     NSTB        = 4,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [NSTB-1:0] STB_IDLE    = 4'b0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sdata_i,
  input  logic [NSTB-1:0] stb_i,
  input  logic            load_a_ni,
  input  logic            load_b_ni,
  input  logic            clr_ni,
  output logic [DW-1:0]   dac_o,
  output logic [DW-1:0]   shreg_o
);
  localparam int unsigned SW = NSTB + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, STB_IDLE};

  logic [SW-1:0]   raw, synced;
  logic [NSTB-1:0] stb_s;
  logic            data_s, ld_a_s, ld_b_s;
  shift_req_t      req;

  assign raw = {load_b_ni, load_a_ni, sdata_i, stb_i};

  sdac_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {ld_b_s, ld_a_s, data_s, stb_s} = synced;

  sdac_edge #(.NSTB(NSTB), .STB_IDLE(STB_IDLE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (stb_s),
    .data_i(data_s),
    .req_o (req)
  );

  sdac_regs #(.DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .req_i  (req),
    .load_i (~ld_a_s & ~ld_b_s),
    .shreg_o(shreg_o),
    .dac_o  (dac_o)
  );
endmodule

// File: rtl/sdac_chk.sv
module sdac_chk #(
  parameter int unsigned DW   = 12,
  parameter int unsigned NSTB = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sdata_i,
  input logic [NSTB-1:0] stb_i,
  input logic            load_a_ni,
  input logic            load_b_ni,
  input logic            clr_ni,
  input logic [DW-1:0]   dac_o,
  input logic [DW-1:0]   shreg_o
);
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
  end
  assign warm = warm_q >= 3'd5;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> dac_o == '0);  // R7

  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && ($past(load_a_ni, 3) || $past(load_b_ni, 3)) && clr_ni && $past(clr_ni)
    |-> $stable(dac_o));  // R6

  AST_DAC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && !$past(load_a_ni, 3) && !$past(load_b_ni, 3) && clr_ni && $past(clr_ni)
    |-> dac_o == $past(shreg_o));  // R8

  AST_SHIFT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && !$stable(shreg_o)
    |-> shreg_o[DW-1:1] == $past(shreg_o[DW-2:0]) && shreg_o[0] == $past(sdata_i, 3));  // R1

  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(stb_i, 3) == $past(stb_i, 4) |-> $stable(shreg_o));  // R5
endmodule

bind sdac_top sdac_chk #(.DW(DW), .NSTB(NSTB)) u_sdac_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sdata_i  (sdata_i),
  .stb_i    (stb_i),
  .load_a_ni(load_a_ni),
  .load_b_ni(load_b_ni),
  .clr_ni   (clr_ni),
  .dac_o    (dac_o),
  .shreg_o  (shreg_o)
);

// File: tb/tb_sdac_top.sv
module tb_sdac_top;
  localparam logic [3:0] IDLE = 4'b0100;

  // {take, block[3:0], data, sel[1:0]}
  localparam logic [7:0] VEC [10] = '{
    8'b1_0000_1_00, 8'b1_0000_0_01, 8'b1_0000_1_10, 8'b1_0000_1_11,
    8'b0_0010_0_00, 8'b0_1000_1_10, 8'b1_0000_0_11, 8'b0_0101_1_01,
    8'b1_0000_0_10, 8'b1_0000_1_00
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdata = 1'b0;
  logic [3:0]  stb = IDLE;
  logic        ld_a = 1'b1, ld_b = 1'b1, clr_n = 1'b1;
  logic [11:0] dac, shreg;
  logic [11:0] model = '0;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sdac_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .stb_i(stb),
    .load_a_ni(ld_a), .load_b_ni(ld_b), .clr_ni(clr_n),
    .dac_o(dac), .shreg_o(shreg)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    waitn(3);
    check("R9 reset shreg", shreg, 12'h000);
    check("R9 reset dac", dac, 12'h000);
    rst_ni = 1'b1;
    waitn(6);
    check("R9 no shift on release", shreg, 12'h000);

    // R1 R2 R3 R4 R5: pulse table
    for (int v = 0; v < 10; v++) begin
      logic [1:0] sel;
      logic       d, take;
      logic [3:0] blk;
      {take, blk, d, sel} = VEC[v];
      sdata = d;
      waitn(1);
      stb = IDLE ^ (blk | (4'b0001 << sel));
      waitn(4);
      if (take) model = {model[10:0], d};
      check(take ? "R1 R2 R3 accepted edge" : "R4 blocked edge", shreg, model);
      stb = IDLE;
      waitn(4);
      check("R5 return edge ignored", shreg, model);
    end

    // R4: strobe 1 held active blocks strobe 2
    sdata = 1'b1;
    waitn(1);
    stb = IDLE ^ 4'b0001;
    waitn(4);
    model = {model[10:0], 1'b1};
    check("R2 first strobe takes bit", shreg, model);
    sdata = 1'b0;
    waitn(1);
    stb = IDLE ^ 4'b0011;
    waitn(4);
    check("R4 held strobe blocks", shreg, model);
    stb = IDLE;
    waitn(4);
    check("R4 release no shift", shreg, model);

    // R10 shift latency on strobe 4
    sdata = 1'b1;
    waitn(1);
    stb = IDLE ^ 4'b1000;
    waitn(2);
    check("R10 shift not before third edge", shreg, model);
    waitn(1);
    model = {model[10:0], 1'b1};
    check("R10 shift at third edge", shreg, model);
    stb = IDLE;
    waitn(4);

    // R6 load needs both lines
    ld_a = 1'b0;
    waitn(5);
    check("R6 only load_a low", dac, 12'h000);
    ld_a = 1'b1; ld_b = 1'b0;
    waitn(5);
    check("R6 only load_b low", dac, 12'h000);
    ld_b = 1'b1;
    waitn(4);
    ld_a = 1'b0; ld_b = 1'b0;
    waitn(2);
    check("R10 load not before third edge", dac, 12'h000);
    waitn(1);
    check("R10 R6 load at third edge", dac, model);
    ld_a = 1'b1; ld_b = 1'b1;
    waitn(4);

    // R7 R8 clear
    #2 clr_n = 1'b0;
    #1 check("R7 async clear", dac, 12'h000);
    check("R7 shreg kept", shreg, model);
    waitn(1);
    ld_a = 1'b0; ld_b = 1'b0;
    waitn(5);
    check("R8 load ignored in clear", dac, 12'h000);
    clr_n = 1'b1;
    waitn(3);
    check("R8 load after clear", dac, model);
    ld_a = 1'b1; ld_b = 1'b1;
    waitn(4);

    // R9 reset mid-run
    rst_ni = 1'b0;
    waitn(2);
    check("R9 reset clears dac", dac, 12'h000);
    check("R9 reset clears shreg", shreg, 12'h000);
    rst_ni = 1'b1;
    waitn(6);
    check("R9 quiet after release", shreg, 12'h000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule